// File: doc/BRIEF.md
# Associative-Data SRAM Access Sequencer

This block is the device-side controller that lets a host reach the external SRAM holding associative data behind a search coprocessor. The host issues a read or a write as a two-cycle command on a shared command bus with a valid strobe. The coprocessor's data bus carries the SRAM index, a space selector and the target device ID. When the selector picks the SRAM space and the ID matches, the block builds a 24-bit SRAM address. It presents that address on the SRAM address bus with one-cycle active-low chip-enable and address-latch strobes, after a programmable pipeline delay.

Reads block the command bus. The host releases the shared data bus for two turnaround cycles. The device then drives the data bus and the acknowledge line, pulses the acknowledge after an extra programmable hold delay, and hands both lines back. Writes are pipelined: they raise no acknowledge, and the next command may follow at once. Every tri-state pin is modelled as a data-out and output-enable pair.

Top module: `sram_access_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, `ack_oe`, `dq_oe`, `sadr_oe`, `ack` and `err` are low, `ce_n`, `ale_n` and `we_n` are high, and `sadr` is zero.
- R2: A command is accepted only if four conditions hold. `cmd_valid` is high in both phases. `cmd[1:0]` carries the same opcode in both phases (read = 2'b01, write = 2'b10). In phase A, `dq_in[20:19]` = 2'b10 and `dq_in[25:21]` = `dev_id`. Any other traffic causes no bus activity.
- R3: The SRAM address is `{cmd[8:6], dev_id, dq_in[15:0]}`, all taken in phase A. `sadr` reads zero whenever it is not presented.
- R4: Count the phase-B cycle of an accepted read as cycle 0, and let TL = `cfg_tl` and HL = `cfg_hl`. `dq_oe` is high from cycle 3 through cycle 4+TL+HL. `ack_oe` is high from cycle 3 through cycle 5+TL+HL. `dq_out` is all zeros.
- R5: For every accepted command, `sadr_oe` is high and `ce_n` and `ale_n` are low for exactly one cycle, cycle 4+TL, and are idle at every other time.
- R6: For a read, `ack` is high only in cycle 4+TL+HL. It is low in every other cycle in which `ack_oe` is high, including cycle 5+TL+HL, when `dq_oe` has already dropped.
- R7: While a read is outstanding (cycles 1 through 5+TL+HL), any cycle with `cmd_valid` high is ignored and raises `err` for one cycle on the next cycle. A phase A in cycle 6+TL+HL is accepted.
- R8: Writes raise neither `ack_oe` nor `dq_oe`. A write's strobe cycle has `we_n` low, and `we_n` is high at every other time. A new command may start in the cycle right after a write's phase B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command valid strobe |
| cmd | input | 9 | Command bus: opcode [1:0], upper SRAM address [8:6] |
| dq_in | input | 72 | Shared data bus, host-driven value |
| dq_out | output | 72 | Shared data bus, device-driven value |
| dq_oe | output | 1 | Device drives the shared data bus |
| dev_id | input | 5 | This device's ID |
| cfg_tl | input | 2 | Search-pipeline latency setting |
| cfg_hl | input | 3 | Acknowledge hold latency setting |
| ack | output | 1 | Acknowledge value |
| ack_oe | output | 1 | Acknowledge output enable |
| sadr | output | 24 | SRAM address |
| sadr_oe | output | 1 | SRAM address output enable |
| ce_n | output | 1 | SRAM chip enable, active low |
| ale_n | output | 1 | SRAM address latch enable, active low |
| we_n | output | 1 | SRAM write enable, active low |
| err | output | 1 | Pulse: command dropped during an outstanding read |

## Verification
The bench sweeps all 32 latency pairs, because a design that adds the hold latency to the address delay, or counts from phase A, puts the strobe or the acknowledge one or more cycles off. It issues commands exactly on the last busy cycle and on the first free cycle. A design whose blocking window is one cycle too short or too long either accepts a command it should drop or misses a legal one, which shows up as a missing or extra strobe and `err` pulse. Back-to-back writes at the deepest latency catch a pipeline that loses overlapping entries. Commands with a wrong ID, a wrong selector, a reserved opcode, a dropped strobe or a changed opcode in phase B catch a decoder that wakes the SRAM bus for traffic that is not its own.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_RD  = 2'b01,
    OP_WR  = 2'b10,
    OP_RSV = 2'b11
  } seq_op_e;

  localparam logic [1:0] SPACE_SRAM = 2'b10;

  typedef enum logic {
    DEC_IDLE = 1'b0,
    DEC_HAVE_A = 1'b1
  } dec_state_e;
endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_seq_pkg::*;
#(
  parameter int CMD_W = 9,
  parameter int DQ_W = 72,
  parameter int IDX_W = 16,
  parameter int ID_W = 5,
  parameter int HI_W = 3,
  parameter int HI_LSB = 6,
  parameter int SEL_LSB = 19,
  parameter int ID_LSB = 21,
  localparam int ADR_W = HI_W + ID_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd,
  input  logic [DQ_W-1:0]  dq_in,
  input  logic [ID_W-1:0]  dev_id,
  input  logic             busy,
  output logic             issue,
  output logic             issue_wr,
  output logic [ADR_W-1:0] issue_adr,
  output logic             err
);
  dec_state_e       state_q;
  seq_op_e          op_q;
  logic [ADR_W-1:0] adr_q;
  logic             err_q;
  logic             a_ok;
  seq_op_e          op_in;

  assign op_in = seq_op_e'(cmd[1:0]);
  assign a_ok = cmd_valid && (op_in == OP_RD || op_in == OP_WR)
             && dq_in[SEL_LSB +: 2] == SPACE_SRAM
             && dq_in[ID_LSB +: ID_W] == dev_id;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DEC_IDLE;
      op_q    <= OP_NOP;
      adr_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state_q)
        DEC_IDLE: begin
          if (cmd_valid && busy) begin
            err_q <= 1'b1;
          end else if (a_ok) begin
            state_q <= DEC_HAVE_A;
            op_q    <= op_in;
            adr_q   <= {cmd[HI_LSB +: HI_W], dev_id, dq_in[IDX_W-1:0]};
          end
        end
        default: state_q <= DEC_IDLE;
      endcase
    end
  end

  assign issue     = (state_q == DEC_HAVE_A) && cmd_valid && (op_in == op_q);
  assign issue_wr  = (op_q == OP_WR);
  assign issue_adr = adr_q;
  assign err       = err_q;
endmodule

// File: rtl/sram_addr_pipe.sv
module sram_addr_pipe #(
  parameter int ADR_W = 24,
  parameter int TL_W = 2,
  localparam int DEPTH = 2 + (1 << TL_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins,
  input  logic             ins_wr,
  input  logic [ADR_W-1:0] ins_adr,
  input  logic [TL_W-1:0]  tl,
  output logic [ADR_W-1:0] sadr,
  output logic             sadr_oe,
  output logic             ce_n,
  output logic             ale_n,
  output logic             we_n
);
  localparam int SLOT_W = $clog2(DEPTH);

  logic             vld [DEPTH];
  logic             wr  [DEPTH];
  logic [ADR_W-1:0] adr [DEPTH];
  logic [SLOT_W-1:0] slot;

  // entry enters so that it leaves stage 0 in cycle 3+tl, strobe in 4+tl
  assign slot = SLOT_W'(2) + SLOT_W'(tl);

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        vld[g] <= 1'b0;
        wr[g]  <= 1'b0;
        adr[g] <= '0;
      end else if (ins && slot == SLOT_W'(g)) begin
        vld[g] <= 1'b1;
        wr[g]  <= ins_wr;
        adr[g] <= ins_adr;
      end else if (g == DEPTH - 1) begin
        vld[g] <= 1'b0;
        wr[g]  <= 1'b0;
        adr[g] <= '0;
      end else begin
        vld[g] <= vld[(g + 1) % DEPTH];
        wr[g]  <= wr[(g + 1) % DEPTH];
        adr[g] <= adr[(g + 1) % DEPTH];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sadr    <= '0;
      sadr_oe <= 1'b0;
      ce_n    <= 1'b1;
      ale_n   <= 1'b1;
      we_n    <= 1'b1;
    end else begin
      sadr    <= vld[0] ? adr[0] : '0;
      sadr_oe <= vld[0];
      ce_n    <= ~vld[0];
      ale_n   <= ~vld[0];
      we_n    <= ~(vld[0] & wr[0]);
    end
  end
endmodule

// File: rtl/sram_read_ctl.sv
module sram_read_ctl #(
  parameter int TL_W = 2,
  parameter int HL_W = 3,
  localparam int CNT_W = $clog2(7 + (1 << TL_W) + (1 << HL_W))
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [TL_W-1:0] tl,
  input  logic [HL_W-1:0] hl,
  output logic            busy,
  output logic            ack,
  output logic            ack_oe,
  output logic            dq_oe
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nk;
  logic [CNT_W-1:0] k_ack;

  assign nk    = cnt_q + CNT_W'(1);
  assign k_ack = CNT_W'(4) + CNT_W'(tl) + CNT_W'(hl);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      ack      <= 1'b0;
      ack_oe   <= 1'b0;
      dq_oe    <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(1);
      ack      <= 1'b0;
      ack_oe   <= 1'b0;
      dq_oe    <= 1'b0;
    end else if (active_q) begin
      cnt_q  <= nk;
      ack_oe <= (nk >= CNT_W'(3)) && (nk <= k_ack + CNT_W'(1));
      dq_oe  <= (nk >= CNT_W'(3)) && (nk <= k_ack);
      ack    <= (nk == k_ack);
      if (nk == k_ack + CNT_W'(2)) active_q <= 1'b0;
    end
  end

  assign busy = active_q;
endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
  import sram_seq_pkg::*;
#(
  parameter int CMD_W = 9,
  parameter int DQ_W = 72,
  parameter int IDX_W = 16,
  parameter int ID_W = 5,
  parameter int HI_W = 3,
  parameter int HI_LSB = 6,
  parameter int SEL_LSB = 19,
  parameter int ID_LSB = 21,
  parameter int TL_W = 2,
  parameter int HL_W = 3,
  localparam int ADR_W = HI_W + ID_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd,
  input  logic [DQ_W-1:0]  dq_in,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe,
  input  logic [ID_W-1:0]  dev_id,
  input  logic [TL_W-1:0]  cfg_tl,
  input  logic [HL_W-1:0]  cfg_hl,
  output logic             ack,
  output logic             ack_oe,
  output logic [ADR_W-1:0] sadr,
  output logic             sadr_oe,
  output logic             ce_n,
  output logic             ale_n,
  output logic             we_n,
  output logic             err
);
  logic             busy;
  logic             issue;
  logic             issue_wr;
  logic [ADR_W-1:0] issue_adr;

  sram_cmd_decode #(
    .CMD_W(CMD_W), .DQ_W(DQ_W), .IDX_W(IDX_W), .ID_W(ID_W),
    .HI_W(HI_W), .HI_LSB(HI_LSB), .SEL_LSB(SEL_LSB), .ID_LSB(ID_LSB)
  ) u_dec (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .dq_in(dq_in),
    .dev_id(dev_id), .busy(busy), .issue(issue), .issue_wr(issue_wr),
    .issue_adr(issue_adr), .err(err)
  );

  sram_addr_pipe #(.ADR_W(ADR_W), .TL_W(TL_W)) u_pipe (
    .clk(clk), .rst(rst), .ins(issue), .ins_wr(issue_wr), .ins_adr(issue_adr),
    .tl(cfg_tl), .sadr(sadr), .sadr_oe(sadr_oe), .ce_n(ce_n), .ale_n(ale_n),
    .we_n(we_n)
  );

  sram_read_ctl #(.TL_W(TL_W), .HL_W(HL_W)) u_rd (
    .clk(clk), .rst(rst), .start(issue && !issue_wr), .tl(cfg_tl), .hl(cfg_hl),
    .busy(busy), .ack(ack), .ack_oe(ack_oe), .dq_oe(dq_oe)
  );

  // bus is held at a defined level while the device owns it
  assign dq_out = '0;
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic ack,
  input logic ack_oe,
  input logic dq_oe,
  input logic ce_n,
  input logic ale_n,
  input logic sadr_oe,
  input logic we_n,
  input logic err
);
  AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (rst)
    !ce_n |-> (sadr_oe && !ale_n)); // R5
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !ce_n |=> ce_n); // R5
  AST_READ_STROBE_IN_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && we_n) |-> dq_oe); // R4
  AST_ACK_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    ack |-> (ack_oe && dq_oe)); // R6
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R6
  AST_DQ_HANDOVER: assert property (@(posedge clk) disable iff (rst)
    $fell(dq_oe) |-> (ack_oe && !ack)); // R6
  AST_ERR_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(cmd_valid)); // R7
  AST_WRITE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce_n && !ack)); // R8
endmodule

bind sram_access_seq sram_seq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .ack(ack), .ack_oe(ack_oe),
  .dq_oe(dq_oe), .ce_n(ce_n), .ale_n(ale_n), .sadr_oe(sadr_oe), .we_n(we_n),
  .err(err)
);

// File: tb/tb_sram_access_seq.sv
module tb_sram_access_seq;
  localparam logic [4:0] MY_ID = 5'h0B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [8:0]  cmd = '0;
  logic [71:0] dq_in = '0;
  logic [71:0] dq_out;
  logic        dq_oe;
  logic [1:0]  cfg_tl = '0;
  logic [2:0]  cfg_hl = '0;
  logic        ack, ack_oe, sadr_oe, ce_n, ale_n, we_n, err;
  logic [23:0] sadr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int busy_until = 0;
  int last_evt = 0;
  int stb_seen = 0;
  bit chk_en = 1'b0;

  logic [63:0] e_ackoe = '0, e_ack = '0, e_dqoe = '0, e_stb = '0, e_wr = '0, e_err = '0;
  logic [23:0] e_adr [64];

  sram_access_seq dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .dev_id(MY_ID), .cfg_tl(cfg_tl),
    .cfg_hl(cfg_hl), .ack(ack), .ack_oe(ack_oe), .sadr(sadr),
    .sadr_oe(sadr_oe), .ce_n(ce_n), .ale_n(ale_n), .we_n(we_n), .err(err)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      int s;
      s = cyc % 64;
      if (!ce_n) stb_seen++;
      chk("R4 ack_oe", 32'(ack_oe), 32'(e_ackoe[s]));
      chk("R4 dq_oe/dq_out", {31'(dq_oe), |dq_out}, {31'(e_dqoe[s]), 1'b0});
      chk("R6 ack", 32'(ack), 32'(e_ack[s]));
      chk("R5 strobes", 32'({sadr_oe, !ce_n, !ale_n}), 32'({3{e_stb[s]}}));
      chk("R8 we_n", 32'(!we_n), 32'(e_wr[s]));
      chk("R3 sadr", 32'(sadr), 32'(e_adr[s]));
      chk("R7 err", 32'(err), 32'(e_err[s]));
      e_ackoe[s] = 1'b0; e_ack[s] = 1'b0; e_dqoe[s] = 1'b0;
      e_stb[s] = 1'b0; e_wr[s] = 1'b0; e_err[s] = 1'b0; e_adr[s] = '0;
    end
  end

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic idle_cyc();
    cmd_valid = 1'b0;
    cmd = 9'($urandom);
    dq_in = {$urandom, $urandom, $urandom};
    @(negedge clk);
  endtask

  task automatic wait_ready();
    while (cyc < busy_until) idle_cyc();
  endtask

  task automatic drain();
    while (cyc <= last_evt) idle_cyc();
  endtask

  task automatic set_cfg(input int tl, input int hl);
    drain();
    cfg_tl = 2'(tl);
    cfg_hl = 3'(hl);
    idle_cyc();
  endtask

  // phb: 0 = proper phase B, 1 = strobe dropped, 2 = opcode changed
  task automatic issue(input logic [1:0] op, input int phb, input logic [4:0] id,
                       input logic [1:0] sel);
    logic [2:0]  hi;
    logic [15:0] idx;
    int a, pb, tl, hl;
    bit ok;
    hi = 3'($urandom);
    idx = 16'($urandom);
    tl = int'(cfg_tl);
    hl = int'(cfg_hl);
    a = cyc;
    pb = a + 1;
    ok = (op == 2'b01 || op == 2'b10) && id == MY_ID && sel == 2'b10 && phb == 0;
    cmd_valid = 1'b1;
    cmd = {hi, 4'($urandom), op};
    dq_in = {46'($urandom), id, sel, 3'($urandom), idx};
    @(negedge clk);
    cmd_valid = (phb != 1);
    if (phb == 2) cmd[1:0] = (op == 2'b01) ? 2'b10 : 2'b01;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (ok) begin
      e_stb[(pb + 4 + tl) % 64] = 1'b1;
      e_adr[(pb + 4 + tl) % 64] = {hi, MY_ID, idx};
      if (op == 2'b10) begin
        e_wr[(pb + 4 + tl) % 64] = 1'b1;
        last_evt = imax(last_evt, pb + 4 + tl);
      end else begin
        for (int k = 3; k <= 5 + tl + hl; k++) begin
          e_ackoe[(pb + k) % 64] = 1'b1;
          if (k <= 4 + tl + hl) e_dqoe[(pb + k) % 64] = 1'b1;
        end
        e_ack[(pb + 4 + tl + hl) % 64] = 1'b1;
        busy_until = pb + 6 + tl + hl;
        last_evt = imax(last_evt, pb + 5 + tl + hl);
      end
    end
  endtask

  // single-cycle command attempt while a read is outstanding
  task automatic reject_pulse();
    if (cyc < busy_until) begin
      cmd_valid = 1'b1;
      cmd = {3'($urandom), 4'($urandom), 2'b10};
      dq_in = {46'($urandom), MY_ID, 2'b10, 3'($urandom), 16'($urandom)};
      e_err[(cyc + 1) % 64] = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  initial begin
    int r, s0;
    void'($urandom(32'd24681));
    for (int i = 0; i < 64; i++) e_adr[i] = '0;
    @(negedge clk);
    @(negedge clk);
    // R1: outputs idle while reset is held
    chk("R1 reset", {ack_oe, dq_oe, sadr_oe, ack, err, ce_n, ale_n, we_n, |sadr},
        {8'b0000_0111, 1'b0});
    @(negedge clk);
    rst = 1'b0;
    chk_en = 1'b1;
    @(negedge clk);

    // R4 R5 R6 R7: every latency pair, write issued on the first free cycle
    for (int tl = 0; tl < 4; tl++) begin
      for (int hl = 0; hl < 8; hl++) begin
        set_cfg(tl, hl);
        issue(2'b01, 0, MY_ID, 2'b10);
        wait_ready();
        issue(2'b10, 0, MY_ID, 2'b10);
      end
    end

    // R8: back-to-back writes at deepest and shallowest latency, then a read
    set_cfg(3, 2);
    for (int i = 0; i < 4; i++) issue(2'b10, 0, MY_ID, 2'b10);
    issue(2'b01, 0, MY_ID, 2'b10);
    wait_ready();
    set_cfg(0, 0);
    for (int i = 0; i < 4; i++) issue(2'b10, 0, MY_ID, 2'b10);
    issue(2'b01, 0, MY_ID, 2'b10);

    // R7: rejected attempts at the start and on the last busy cycle
    reject_pulse();
    reject_pulse();
    while (cyc < busy_until - 1) idle_cyc();
    reject_pulse();
    issue(2'b01, 0, MY_ID, 2'b10);
    wait_ready();

    // R2: traffic not addressed to this SRAM space produces no strobe
    drain();
    s0 = stb_seen;
    issue(2'b01, 0, MY_ID ^ 5'h01, 2'b10);
    issue(2'b10, 0, MY_ID ^ 5'h10, 2'b10);
    issue(2'b01, 0, MY_ID, 2'b00);
    issue(2'b10, 0, MY_ID, 2'b11);
    issue(2'b00, 0, MY_ID, 2'b10);
    issue(2'b11, 0, MY_ID, 2'b10);
    issue(2'b01, 1, MY_ID, 2'b10);
    issue(2'b10, 2, MY_ID, 2'b10);
    for (int i = 0; i < 12; i++) idle_cyc();
    chk("R2 no strobe for foreign traffic", 32'(stb_seen - s0), 32'd0);

    // constrained random mix
    for (int it = 0; it < 500; it++) begin
      r = int'($urandom % 16);
      wait_ready();
      if (r <= 5) begin
        issue(2'b01, 0, MY_ID, 2'b10);
        if ($urandom % 3 == 0) reject_pulse();
      end else if (r <= 10) issue(2'b10, 0, MY_ID, 2'b10);
      else if (r == 11) issue(2'($urandom % 2 + 1), 0, MY_ID ^ 5'(1 << ($urandom % 5)), 2'b10);
      else if (r == 12) issue(2'($urandom % 2 + 1), 0, MY_ID, 2'($urandom % 2));
      else if (r == 13) issue(($urandom % 2 == 0) ? 2'b00 : 2'b11, 0, MY_ID, 2'b10);
      else if (r == 14) issue(2'($urandom % 2 + 1), int'($urandom % 2) + 1, MY_ID, 2'b10);
      else set_cfg(int'($urandom % 4), int'($urandom % 8));
      for (int g = int'($urandom % 3); g > 0; g--) idle_cyc();
    end
    wait_ready();
    drain();
    for (int i = 0; i < 4; i++) idle_cyc();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog cyc=%0d actual=running expected=done", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule